// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block sits beside an analog-to-digital converter and watches its stream of finished conversions. Each result arrives with a one-cycle valid strobe, the number of the channel it came from and a 12-bit unsigned value. Two comparator units each watch one chosen channel. A unit raises its sticky flag only after that channel has met the unit's threshold condition on a programmed number of back-to-back conversions. A single crossing caused by a noise spike is therefore not reported.

Each unit is configured with one write. The write carries an enable, an interrupt enable, a condition bit, a channel number, a 12-bit threshold and a 4-bit run-length field that holds the required count minus one. Unit 0 also has a window bit. When it is set, a result counts for unit 0 only if it meets the conditions of both units, so two thresholds bound a band. Software clears the flags by writing ones to a status word. A registered interrupt line follows the flags whose interrupt enables are set. Results are taken as straight binary only.

Top module: `adc_thresh_mon`

## Requirements
- R1: After a synchronous reset, both flags and the interrupt are 0 and both units are disabled. Results then set no flag until a unit is configured.
- R2: Condition bit 0 matches when the result is strictly less than the threshold. Condition bit 1 matches when the result is greater than or equal to it. A result equal to the threshold therefore matches only under condition 1.
- R3: With run-length field F (0 to 15), a unit's flag is set by the clock edge that samples the (F+1)-th consecutive matching result of its channel. Field 0 needs one match and field 15 needs sixteen.
- R4: A result on the watched channel that fails the condition resets that unit's run count to zero.
- R5: Results on other channels, and cycles without a valid strobe, leave the run count unchanged.
- R6: Setting a flag restarts the run count at zero, so a further full run is needed before the flag can be set again.
- R7: A status write clears flag 0 when bit 1 is 1 and flag 1 when bit 2 is 1. Bit 0 and zero bits have no effect. A flag stays set until it is cleared this way. If a set and a clear reach the same flag in one cycle, the set wins.
- R8: When unit 0's window bit is set, a result on unit 0's channel counts for unit 0 only if unit 1 is enabled and the result meets both units' conditions. Unit 1 still counts on its own channel.
- R9: Any configuration write to a unit restarts its run count at zero. This includes a write with all fields zero, which disables the unit. A disabled unit never sets its flag.
- R10: The interrupt output is registered. It is 1 in the cycle after some flag is 1 with that unit's interrupt enable set, and 0 in the cycle after no such flag exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_chan | input | 5 | Channel number of the result |
| res_data | input | 12 | Unsigned conversion result |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 1 | Unit addressed by the write (0 or 1) |
| cfg_en | input | 1 | Unit enable |
| cfg_win | input | 1 | Window bit; stored for unit 0 only |
| cfg_ie | input | 1 | Interrupt enable for the unit's flag |
| cfg_cond | input | 1 | 0: less than, 1: greater or equal |
| cfg_chan | input | 5 | Channel the unit watches |
| cfg_value | input | 12 | Threshold |
| cfg_mfield | input | 4 | Required run length minus one |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Write-one-to-clear: bit 1 clears flag 0, bit 2 clears flag 1 |
| cmp_flag | output | 2 | Sticky flags, bit k for unit k |
| irq | output | 1 | Registered interrupt |

## Verification
The bench attacks the off-by-one points. These are a result exactly equal to the threshold, a run of one and a run of sixteen, and the count restarting after a flag. A design that restarted late or kept counting would set a second flag one conversion early. Other checks put a failing result or a foreign-channel result inside a run; a design that mishandled these would flag too soon or never. Window mode is fed results that pass only one of the two conditions, which would wrongly set flag 0 in a design that checked just one side. The bench also drives a clear and a set into one flag in the same cycle, where losing the set would drop an event. Finally, it rewrites a unit in the middle of a run, where a stale count would fire the flag one result early.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
  localparam int CH_W = 5;   // channel number width
  localparam int DW   = 12;  // result / threshold width
  localparam int MW   = 4;   // run-length field width

  typedef enum logic {
    COND_LT = 1'b0,
    COND_GE = 1'b1
  } cmp_cond_e;

  typedef struct packed {
    logic              en;
    logic              win;
    logic              ie;
    cmp_cond_e         cond;
    logic [CH_W-1:0]   chan;
    logic [DW-1:0]     value;
    logic [MW-1:0]     mfield;
  } cmp_cfg_t;
endpackage

// File: rtl/adc_cmp_unit.sv
module adc_cmp_unit
  import adc_mon_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  cmp_cfg_t        cfg,
  input  logic            win_en,
  input  logic            partner_ok,
  input  logic            vld,
  input  logic [CH_W-1:0] chan,
  input  logic [DW-1:0]   data,
  input  logic            clr,
  output logic            raw_hit,
  output logic [MW-1:0]   cnt,
  output logic            flag
);
  logic sel;
  logic qual;
  logic run_done;
  logic set_now;

  always_comb begin
    raw_hit  = (cfg.cond == COND_GE) ? (data >= cfg.value) : (data < cfg.value);
    qual     = raw_hit && (!win_en || partner_ok);
    sel      = vld && cfg.en && (chan == cfg.chan);
    run_done = (cnt == cfg.mfield);
    set_now  = !cfg_wr && sel && qual && run_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cfg_wr) begin
      cnt <= '0;
    end else if (sel) begin
      if (!qual || run_done) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_now) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
  import adc_mon_pkg::*;
#(
  parameter int CHW = CH_W,
  parameter int RW  = DW,
  parameter int FW  = MW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           res_valid,
  input  logic [CHW-1:0] res_chan,
  input  logic [RW-1:0]  res_data,
  input  logic           cfg_we,
  input  logic           cfg_idx,
  input  logic           cfg_en,
  input  logic           cfg_win,
  input  logic           cfg_ie,
  input  logic           cfg_cond,
  input  logic [CHW-1:0] cfg_chan,
  input  logic [RW-1:0]  cfg_value,
  input  logic [FW-1:0]  cfg_mfield,
  input  logic           sts_we,
  input  logic [2:0]     sts_wdata,
  output logic [1:0]     cmp_flag,
  output logic           irq
);
  localparam int NCMP = 2;

  cmp_cfg_t          cfg_q   [NCMP];
  logic [NCMP-1:0]   raw_hit;
  logic [NCMP-1:0]   cfg_wr;
  logic [NCMP-1:0]   en_vec;
  logic [NCMP-1:0]   ie_vec;
  logic [FW-1:0]     cnt0;
  logic [FW-1:0]     cnt1;
  logic [FW-1:0]     mf0;
  logic [FW-1:0]     mf1;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    cmp_cfg_t wr_cfg;
    logic     clr_k;
    logic [FW-1:0] cnt_k;

    always_comb begin
      wr_cfg        = '0;
      wr_cfg.en     = cfg_en;
      wr_cfg.win    = (k == 0) ? cfg_win : 1'b0;
      wr_cfg.ie     = cfg_ie;
      wr_cfg.cond   = cmp_cond_e'(cfg_cond);
      wr_cfg.chan   = cfg_chan;
      wr_cfg.value  = cfg_value;
      wr_cfg.mfield = cfg_mfield;
      cfg_wr[k]     = cfg_we && (cfg_idx == k[0]);
      clr_k         = sts_we && sts_wdata[k+1];
      en_vec[k]     = cfg_q[k].en;
      ie_vec[k]     = cfg_q[k].ie;
    end

    always_ff @(posedge clk) begin
      if (rst)            cfg_q[k] <= '0;
      else if (cfg_wr[k]) cfg_q[k] <= wr_cfg;
    end

    adc_cmp_unit i_unit (
      .clk        (clk),
      .rst        (rst),
      .cfg_wr     (cfg_wr[k]),
      .cfg        (cfg_q[k]),
      .win_en     (cfg_q[k].win),
      .partner_ok (cfg_q[NCMP-1-k].en && raw_hit[NCMP-1-k]),
      .vld        (res_valid),
      .chan       (res_chan),
      .data       (res_data),
      .clr        (clr_k),
      .raw_hit    (raw_hit[k]),
      .cnt        (cnt_k),
      .flag       (cmp_flag[k])
    );
  end

  assign cnt0 = g_cmp[0].cnt_k;
  assign cnt1 = g_cmp[1].cnt_k;
  assign mf0  = cfg_q[0].mfield;
  assign mf1  = cfg_q[1].mfield;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(cmp_flag & ie_vec);
  end
endmodule

// File: rtl/adc_mon_chk.sv
module adc_mon_chk #(
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          res_valid,
  input logic          sts_we,
  input logic [2:0]    sts_wdata,
  input logic [1:0]    cmp_flag,
  input logic          irq,
  input logic [1:0]    en_vec,
  input logic [1:0]    ie_vec,
  input logic [FW-1:0] cnt0,
  input logic [FW-1:0] cnt1,
  input logic [FW-1:0] mf0,
  input logic [FW-1:0] mf1
);
  // R7: a flag holds until a matching clear bit is written
  a_r7_flag0_sticky: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag[0] && !(sts_we && sts_wdata[1])) |=> cmp_flag[0]);
  a_r7_flag1_sticky: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag[1] && !(sts_we && sts_wdata[2])) |=> cmp_flag[1]);

  // R3: a flag rises only on the edge that samples a result
  a_r3_rise_on_result: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmp_flag[0]) || $rose(cmp_flag[1])) |-> $past(res_valid));

  // R9: a disabled unit never raises its flag
  a_r9_unit0_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag[0]) |-> $past(en_vec[0]));
  a_r9_unit1_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag[1]) |-> $past(en_vec[1]));

  // R3: the run count never passes the programmed field
  a_r3_cnt0_bound: assert property (@(posedge clk) disable iff (rst)
    $stable(mf0) |-> (cnt0 <= mf0));
  a_r3_cnt1_bound: assert property (@(posedge clk) disable iff (rst)
    $stable(mf1) |-> (cnt1 <= mf1));

  // R10: interrupt follows enabled flags one cycle later
  a_r10_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(cmp_flag & ie_vec)) |=> irq);
  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(cmp_flag & ie_vec)) |=> !irq);
endmodule

bind adc_thresh_mon adc_mon_chk #(.FW(FW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .res_valid (res_valid),
  .sts_we    (sts_we),
  .sts_wdata (sts_wdata),
  .cmp_flag  (cmp_flag),
  .irq       (irq),
  .en_vec    (en_vec),
  .ie_vec    (ie_vec),
  .cnt0      (cnt0),
  .cnt1      (cnt1),
  .mf0       (mf0),
  .mf1       (mf1)
);

// File: tb/test_adc_thresh_mon.sv
module test_adc_thresh_mon;
  localparam int PERIOD = 10;
  localparam int NVEC   = 12;
  // {valid, clear flag0, chan[4:0], data[11:0], expected flag0}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 5'd3, 12'h900, 1'b0},  // R3 run 1
    {1'b1, 1'b0, 5'd5, 12'h100, 1'b0},  // R5 other channel
    {1'b0, 1'b0, 5'd3, 12'h000, 1'b0},  // R5 idle
    {1'b1, 1'b0, 5'd3, 12'h800, 1'b0},  // R2 equal matches GE
    {1'b1, 1'b0, 5'd3, 12'hFFF, 1'b1},  // R3 third match sets
    {1'b1, 1'b0, 5'd3, 12'h900, 1'b1},  // R6 run restarts, sticky
    {1'b0, 1'b1, 5'd0, 12'h000, 1'b0},  // R7 clear
    {1'b1, 1'b0, 5'd3, 12'h900, 1'b0},  // R6 run 2
    {1'b1, 1'b0, 5'd3, 12'h7FF, 1'b0},  // R4 fail resets
    {1'b1, 1'b0, 5'd3, 12'hA00, 1'b0},
    {1'b1, 1'b0, 5'd3, 12'hA00, 1'b0},
    {1'b1, 1'b0, 5'd3, 12'hA00, 1'b1}   // R4 set only after fresh run
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_valid = 1'b0;
  logic [4:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        cfg_we = 1'b0, cfg_idx = 1'b0, cfg_en = 1'b0, cfg_win = 1'b0;
  logic        cfg_ie = 1'b0, cfg_cond = 1'b0;
  logic [4:0]  cfg_chan = '0;
  logic [11:0] cfg_value = '0;
  logic [3:0]  cfg_mfield = '0;
  logic        sts_we = 1'b0;
  logic [2:0]  sts_wdata = '0;
  logic [1:0]  cmp_flag;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  adc_thresh_mon i_adc_thresh_mon (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_win(cfg_win), .cfg_ie(cfg_ie), .cfg_cond(cfg_cond), .cfg_chan(cfg_chan),
    .cfg_value(cfg_value), .cfg_mfield(cfg_mfield), .sts_we(sts_we),
    .sts_wdata(sts_wdata), .cmp_flag(cmp_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic idx, input logic en, input logic win,
                           input logic ie, input logic cond, input logic [4:0] ch,
                           input logic [11:0] val, input logic [3:0] mf);
    cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_win = win; cfg_ie = ie;
    cfg_cond = cond; cfg_chan = ch; cfg_value = val; cfg_mfield = mf;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic conv(input logic [4:0] ch, input logic [11:0] d);
    res_valid = 1'b1; res_chan = ch; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic sts_clear(input logic [2:0] bits);
    sts_we = 1'b1; sts_wdata = bits;
    @(negedge clk);
    sts_we = 1'b0; sts_wdata = '0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 flags after reset", cmp_flag, 0);
    chk("R1 irq after reset", irq, 0);
    conv(5'd0, 12'h000);
    chk("R1 unconfigured units stay quiet", cmp_flag, 0);

    // table walk: unit 0 on channel 3, GE 0x800, run of 3
    cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd3, 12'h800, 4'd2);
    for (int i = 0; i < NVEC; i++) begin
      res_valid = VEC[i][19];
      sts_we    = VEC[i][18];
      sts_wdata = VEC[i][18] ? 3'b010 : 3'b000;
      res_chan  = VEC[i][17:13];
      res_data  = VEC[i][12:1];
      @(negedge clk);
      res_valid = 1'b0; sts_we = 1'b0; sts_wdata = '0;
      chk($sformatf("R3/R4/R5/R6 vector %0d flag0", i), cmp_flag[0], VEC[i][0]);
      chk($sformatf("R3 vector %0d flag1", i), cmp_flag[1], 0);
    end
    sts_clear(3'b010);

    // R2: less-than, single-match run, unit 1 with interrupt
    cfg_write(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd7, 12'h010, 4'd0);
    conv(5'd7, 12'h010);
    chk("R2 equal fails LT", cmp_flag[1], 0);
    conv(5'd7, 12'h00F);
    chk("R2 below matches LT, R3 run of one", cmp_flag[1], 1);
    chk("R10 irq not yet", irq, 0);
    @(negedge clk);
    chk("R10 irq one cycle after flag", irq, 1);

    // R7: bit 0 ignored, set beats clear, bit 2 clears
    sts_clear(3'b001);
    chk("R7 bit0 has no effect", cmp_flag[1], 1);
    res_valid = 1'b1; res_chan = 5'd7; res_data = 12'h005;
    sts_we = 1'b1; sts_wdata = 3'b100;
    @(negedge clk);
    res_valid = 1'b0; sts_we = 1'b0; sts_wdata = '0;
    chk("R7 set wins over clear", cmp_flag[1], 1);
    sts_clear(3'b100);
    chk("R7 bit2 clears flag1", cmp_flag[1], 0);
    @(negedge clk);
    chk("R10 irq drops after clear", irq, 0);

    // R3: run of sixteen
    cfg_write(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7, 12'h010, 4'd15);
    for (int i = 0; i < 15; i++) conv(5'd7, 12'h000);
    chk("R3 fifteen matches not enough", cmp_flag[1], 0);
    conv(5'd7, 12'h000);
    chk("R3 sixteenth match sets", cmp_flag[1], 1);
    sts_clear(3'b100);

    // R8: window mode
    cfg_write(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd9, 12'h200, 4'd15);
    cfg_write(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd2, 12'h100, 4'd0);
    conv(5'd2, 12'h300);
    chk("R8 above band, only unit0 side met", cmp_flag[0], 0);
    conv(5'd2, 12'h050);
    chk("R8 below band, only unit1 side met", cmp_flag[0], 0);
    conv(5'd2, 12'h150);
    chk("R8 inside band sets flag0", cmp_flag[0], 1);
    chk("R8 unit1 keeps own channel", cmp_flag[1], 0);
    sts_clear(3'b010);

    // R9: rewrite restarts run; disabled unit quiet
    cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd4, 12'h000, 4'd1);
    conv(5'd4, 12'h005);
    cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd4, 12'h000, 4'd1);
    conv(5'd4, 12'h005);
    chk("R9 rewrite restarted run", cmp_flag[0], 0);
    conv(5'd4, 12'h005);
    chk("R9 full run after rewrite", cmp_flag[0], 1);
    sts_clear(3'b010);
    cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4, 12'h000, 4'd0);
    conv(5'd4, 12'h005);
    chk("R9 disabled unit never flags", cmp_flag[0], 0);
    cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 12'h000, 4'd0);
    conv(5'd0, 12'h000);
    chk("R9 all-zero write disables", cmp_flag[0], 0);

    // R1: reset mid-run clears flag and configuration
    cfg_write(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd4, 12'h000, 4'd0);
    conv(5'd4, 12'h001);
    chk("R1 flag set before reset", cmp_flag[0], 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 flags cleared by reset", cmp_flag, 0);
    chk("R1 irq cleared by reset", irq, 0);
    conv(5'd4, 12'h001);
    chk("R1 units disabled after reset", cmp_flag[0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule